// File: doc/BRIEF.md
# Ring Descriptor Address Generator

This block tracks where the current DMA descriptor sits inside a descriptor table arranged as a ring. It holds a pointer to the current descriptor. Each advance strobe moves the pointer forward by one stride. The stride is the descriptor length plus a programmable gap of unused words. The gap is measured from the last word of one descriptor to the first word of the next. The descriptor length is four words, or eight words when the wide-descriptor select is set. When the current descriptor is flagged as the last one in the ring, an advance sends the pointer back to the table base instead.

Alongside the pointer, a small fetch sequencer walks the word addresses of the current descriptor. A single start pulse begins the walk. The sequencer then offers one word address per cycle and moves to the next word only when the consumer signals ready. Addresses are byte addresses, and every word is 32 bits wide.

Top module: `ring_desc_addr_gen`

## Requirements
- R1: While `rst_n` is low on a clock edge, the pointer loads `base_addr` and any walk is cleared. After reset, `desc_addr` equals `base_addr` and `fetch_valid` is 0.
- R2: With `wide_desc` = 0, an advance without ring end adds 4 × (4 + `skip_words`) bytes to `desc_addr` on the next edge.
- R3: With `wide_desc` = 1, an advance without ring end adds 4 × (8 + `skip_words`) bytes to `desc_addr` on the next edge.
- R4: `skip_words` is a 5-bit count of unused 32-bit words between the end of one descriptor and the start of the next. A value of 0 packs descriptors back to back, and values up to 31 are honoured.
- R5: An advance while `ring_end` = 1 loads `base_addr` into `desc_addr` on the next edge.
- R6: A `restart` pulse loads `base_addr` on the next edge. It takes priority over a simultaneous `advance`.
- R7: With neither `advance` nor `restart` asserted, `desc_addr` holds its value.
- R8: `fetch_start` while idle raises `fetch_valid` on the next edge with word index 0. `fetch_addr` = `desc_addr` + 4 × index. The index moves on only on edges where `fetch_ready` = 1. `fetch_last` marks the final word (index 3, or index 7 when `wide_desc` was set at start). `fetch_valid` drops after the final word is accepted.
- R9: `fetch_start` while a walk is active is ignored, and the walk continues from its current index.
- R10: An `advance` or `restart` ends an active walk, so `fetch_valid` is 0 on the next edge.
- R11: Address arithmetic wraps modulo 2^`ADDR_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_addr | input | ADDR_W | Byte address of the first descriptor in the ring |
| wide_desc | input | 1 | 0: four-word descriptors, 1: eight-word descriptors |
| skip_words | input | SKIP_W | Unused words between consecutive descriptors |
| restart | input | 1 | Reload the pointer from base_addr |
| advance | input | 1 | Move to the next descriptor |
| ring_end | input | 1 | Current descriptor is the last in the ring |
| desc_addr | output | ADDR_W | Byte address of the current descriptor |
| fetch_start | input | 1 | Begin walking the words of the current descriptor |
| fetch_ready | input | 1 | Consumer accepts the offered word address |
| fetch_valid | output | 1 | A word address is being offered |
| fetch_addr | output | ADDR_W | Byte address of the offered word |
| fetch_last | output | 1 | Offered word is the descriptor's final word |

## Verification
Each pointer change, whether from an advance, a ring-end wrap or a restart, is due exactly one edge after the strobe. Each fetch step is also due one edge after a ready cycle. `fetch_valid` is due one edge after a start, advance or restart. The bench drives inputs just after a rising edge and samples outputs after the following rising edge. Each expected pointer is computed as base plus k × 4 × (words + skip), for both descriptor sizes and all 32 skip values. The fetch index is tracked in the bench by counting the ready cycles it has offered, so every comparison lands in the cycle where the registered result first appears.

// File: rtl/rdag_pkg.sv
package rdag_pkg;

   localparam int unsigned WORD_BYTES_LOG2 = 2;
   localparam int unsigned NARROW_WORDS    = 4;
   localparam int unsigned WIDE_WORDS      = 8;
   localparam int unsigned MAX_WORDS       = WIDE_WORDS;
   localparam int unsigned IDX_W           = $clog2(MAX_WORDS);
   localparam int unsigned CNT_W           = IDX_W + 1;

   typedef enum logic {
      DESC_NARROW = 1'b0,
      DESC_WIDE   = 1'b1
   } desc_size_e;

   function automatic logic [CNT_W-1:0] words_of(input desc_size_e sz);
      return (sz == DESC_WIDE) ? CNT_W'(WIDE_WORDS) : CNT_W'(NARROW_WORDS);
   endfunction

endpackage

// File: rtl/rdag_stride.sv
module rdag_stride
   import rdag_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned SKIP_W      = 5,
   parameter bit          ALT_SIZE_EN = 1'b1
) (
   input  logic              wide_sel,
   input  logic [SKIP_W-1:0] skip_words,
   output logic [CNT_W-1:0]  desc_words,
   output logic [ADDR_W-1:0] stride_bytes
);
   localparam int unsigned SUM_W = ((SKIP_W > CNT_W) ? SKIP_W : CNT_W) + 1;

   logic [SUM_W-1:0] span_words;

   generate
      if (ALT_SIZE_EN) begin : g_alt_size
         assign desc_words = words_of(desc_size_e'(wide_sel));
      end else begin : g_fixed_size
         logic unused_sel;
         assign unused_sel = wide_sel;
         assign desc_words = words_of(DESC_NARROW);
      end
   endgenerate

   assign span_words   = SUM_W'(desc_words) + SUM_W'(skip_words);
   assign stride_bytes = ADDR_W'({span_words, {WORD_BYTES_LOG2{1'b0}}});

   initial begin
      AST_STRIDE_FITS : assert (ADDR_W >= SUM_W + WORD_BYTES_LOG2)
         else $error("address too narrow for stride");  // R4
   end

endmodule

// File: rtl/rdag_desc_ptr.sv
module rdag_desc_ptr #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [ADDR_W-1:0] stride_bytes,
   input  logic              restart,
   input  logic              advance,
   input  logic              ring_end,
   output logic [ADDR_W-1:0] desc_addr
);
   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] ptr_d;

   always_comb begin
      ptr_d = ptr_q;
      if (restart) begin
         ptr_d = base_addr;
      end else if (advance) begin
         ptr_d = ring_end ? base_addr : (ptr_q + stride_bytes);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ptr_q <= base_addr;
      else        ptr_q <= ptr_d;
   end

   assign desc_addr = ptr_q;

   AST_RESTART_BASE : assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> desc_addr == $past(base_addr));  // R6
   AST_RING_WRAP : assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !restart && ring_end) |=> desc_addr == $past(base_addr));  // R5
   AST_STEP_STRIDE : assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !restart && !ring_end)
      |=> desc_addr == $past(desc_addr) + $past(stride_bytes));  // R2
   AST_PTR_HOLD : assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !restart) |=> $stable(desc_addr));  // R7

endmodule

// File: rtl/rdag_word_seq.sv
module rdag_word_seq
   import rdag_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cancel,
   input  logic              start,
   input  logic              ready,
   input  logic [CNT_W-1:0]  desc_words,
   input  logic [ADDR_W-1:0] desc_addr,
   output logic              valid,
   output logic [ADDR_W-1:0] word_addr,
   output logic              last
);
   logic              active_q;
   logic [IDX_W-1:0]  idx_q;
   logic [IDX_W-1:0]  lim_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         idx_q    <= '0;
         lim_q    <= '0;
      end else if (cancel) begin
         active_q <= 1'b0;
         idx_q    <= '0;
      end else if (!active_q) begin
         if (start) begin
            active_q <= 1'b1;
            idx_q    <= '0;
            lim_q    <= IDX_W'(desc_words - CNT_W'(1));
         end
      end else if (ready) begin
         if (idx_q == lim_q) begin
            active_q <= 1'b0;
            idx_q    <= '0;
         end else begin
            idx_q <= idx_q + IDX_W'(1);
         end
      end
   end

   assign valid     = active_q;
   assign last      = active_q && (idx_q == lim_q);
   assign word_addr = desc_addr + ADDR_W'({idx_q, {WORD_BYTES_LOG2{1'b0}}});

   AST_IDX_BOUND : assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> idx_q <= lim_q);  // R8
   AST_STEP_ON_READY : assert property (@(posedge clk) disable iff (!rst_n)
      (valid && ready && !last && !cancel) |=> valid && idx_q == $past(idx_q) + IDX_W'(1));  // R8
   AST_STALL_HOLDS : assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready && !cancel) |=> valid && $stable(idx_q));  // R9
   AST_CANCEL_ENDS : assert property (@(posedge clk) disable iff (!rst_n)
      cancel |=> !valid);  // R10

endmodule

// File: rtl/ring_desc_addr_gen.sv
module ring_desc_addr_gen
   import rdag_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned SKIP_W      = 5,
   parameter bit          ALT_SIZE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic              wide_desc,
   input  logic [SKIP_W-1:0] skip_words,
   input  logic              restart,
   input  logic              advance,
   input  logic              ring_end,
   output logic [ADDR_W-1:0] desc_addr,
   input  logic              fetch_start,
   input  logic              fetch_ready,
   output logic              fetch_valid,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic              fetch_last
);
   logic [CNT_W-1:0]  desc_words;
   logic [ADDR_W-1:0] stride_bytes;
   logic              walk_cancel;

   initial begin
      AST_PARAM_ADDR : assert (ADDR_W >= 8 && ADDR_W <= 64)
         else $error("ADDR_W out of range");  // R11
      AST_PARAM_SKIP : assert (SKIP_W >= 1 && SKIP_W <= 8)
         else $error("SKIP_W out of range");  // R4
   end

   assign walk_cancel = restart | advance;

   rdag_stride #(
      .ADDR_W      (ADDR_W),
      .SKIP_W      (SKIP_W),
      .ALT_SIZE_EN (ALT_SIZE_EN)
   ) u_stride (
      .wide_sel     (wide_desc),
      .skip_words   (skip_words),
      .desc_words   (desc_words),
      .stride_bytes (stride_bytes)
   );

   rdag_desc_ptr #(
      .ADDR_W (ADDR_W)
   ) u_ptr (
      .clk          (clk),
      .rst_n        (rst_n),
      .base_addr    (base_addr),
      .stride_bytes (stride_bytes),
      .restart      (restart),
      .advance      (advance),
      .ring_end     (ring_end),
      .desc_addr    (desc_addr)
   );

   rdag_word_seq #(
      .ADDR_W (ADDR_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cancel     (walk_cancel),
      .start      (fetch_start),
      .ready      (fetch_ready),
      .desc_words (desc_words),
      .desc_addr  (desc_addr),
      .valid      (fetch_valid),
      .word_addr  (fetch_addr),
      .last       (fetch_last)
   );

   AST_RESET_IDLE : assert property (@(posedge clk)
      !rst_n |=> !fetch_valid && desc_addr == $past(base_addr));  // R1
   AST_LAST_ONLY_VALID : assert property (@(posedge clk) disable iff (!rst_n)
      fetch_last |-> fetch_valid);  // R8

endmodule

// File: tb/tb_ring_desc_addr_gen.sv
module tb_ring_desc_addr_gen;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] base_addr;
   logic          wide_desc;
   logic [4:0]    skip_words;
   logic          restart, advance, ring_end;
   logic [AW-1:0] desc_addr;
   logic          fetch_start, fetch_ready;
   logic          fetch_valid, fetch_last;
   logic [AW-1:0] fetch_addr;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ring_desc_addr_gen dut (
      .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .wide_desc(wide_desc),
      .skip_words(skip_words), .restart(restart), .advance(advance),
      .ring_end(ring_end), .desc_addr(desc_addr), .fetch_start(fetch_start),
      .fetch_ready(fetch_ready), .fetch_valid(fetch_valid),
      .fetch_addr(fetch_addr), .fetch_last(fetch_last)
   );

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_restart();
      restart = 1'b1; cyc(); restart = 1'b0;
   endtask

   // Walk a descriptor of w words at d; optionally pulse start while active (R9)
   task automatic walk(input int w, input logic [AW-1:0] d, input bit noisy);
      int exp_i = 0;
      bit rdy;
      fetch_start = 1'b1; cyc(); fetch_start = 1'b0;
      for (int c = 0; c < 64 && exp_i < w; c++) begin
         chk("R8 valid", AW'(fetch_valid), 1);
         chk("R8 addr", fetch_addr, d + AW'(4*exp_i));
         chk("R8 last", AW'(fetch_last), AW'(exp_i == w-1));
         rdy = (c % 3) != 1;
         fetch_ready = rdy;
         fetch_start = noisy;
         cyc();
         if (rdy) exp_i++;
      end
      fetch_start = 1'b0; fetch_ready = 1'b0;
      chk("R8 done", AW'(fetch_valid), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [AW-1:0] base, exp;
      int w;
      rst_n = 1'b0; base_addr = 32'h1000_0000; wide_desc = 1'b0; skip_words = '0;
      restart = 1'b0; advance = 1'b0; ring_end = 1'b0;
      fetch_start = 1'b0; fetch_ready = 1'b0;
      repeat (3) cyc();
      rst_n = 1'b1; cyc();
      chk("R1 desc", desc_addr, 32'h1000_0000);
      chk("R1 valid", AW'(fetch_valid), 0);

      // Sweep both sizes and every skip value: R2 R3 R4 R5 R6 R7
      for (int s8 = 0; s8 < 2; s8++) begin
         for (int sk = 0; sk < 32; sk++) begin
            base = 32'h2000_0000 + AW'(sk * 32'h100 + s8 * 32'h1_0000);
            base_addr = base; wide_desc = s8[0]; skip_words = 5'(sk);
            w = s8 ? 8 : 4;
            do_restart();
            chk("R6 restart", desc_addr, base);
            for (int k = 1; k <= 3; k++) begin
               advance = 1'b1; cyc(); advance = 1'b0;
               exp = base + AW'(k * 4 * (w + sk));
               chk(s8 ? "R3 stride" : "R2 stride", desc_addr, exp);
            end
            cyc();
            chk("R7 hold", desc_addr, exp);
            advance = 1'b1; ring_end = 1'b1; cyc(); advance = 1'b0; ring_end = 1'b0;
            chk("R5 wrap", desc_addr, base);
         end
      end

      // R6: restart wins over advance
      base_addr = 32'h3000_0000; wide_desc = 1'b0; skip_words = 5'd2;
      do_restart(); advance = 1'b1; cyc(); advance = 1'b0;
      chk("R6 prio pre", desc_addr, 32'h3000_0018);
      restart = 1'b1; advance = 1'b1; cyc(); restart = 1'b0; advance = 1'b0;
      chk("R6 prio", desc_addr, 32'h3000_0000);

      // R8 / R9: walks for both sizes, with and without start noise
      for (int s8 = 0; s8 < 2; s8++) begin
         for (int nz = 0; nz < 2; nz++) begin
            wide_desc = s8[0]; skip_words = 5'd1;
            do_restart(); advance = 1'b1; cyc(); advance = 1'b0;
            w = s8 ? 8 : 4;
            walk(w, 32'h3000_0000 + AW'(4 * (w + 1)), nz[0]);
         end
      end
      // R9: size latched at start even if select changes mid-walk
      wide_desc = 1'b0; do_restart();
      fetch_start = 1'b1; cyc(); fetch_start = 1'b0; wide_desc = 1'b1;
      fetch_ready = 1'b1; repeat (3) cyc(); fetch_ready = 1'b0;
      chk("R9 latched last", AW'(fetch_last), 1);
      chk("R9 latched addr", fetch_addr, 32'h3000_000C);
      fetch_ready = 1'b1; cyc(); fetch_ready = 1'b0;
      chk("R9 latched end", AW'(fetch_valid), 0);

      // R10: advance and restart cut an active walk
      wide_desc = 1'b1; skip_words = '0; do_restart();
      fetch_start = 1'b1; cyc(); fetch_start = 1'b0;
      fetch_ready = 1'b1; cyc(); fetch_ready = 1'b0;
      chk("R10 mid addr", fetch_addr, 32'h3000_0004);
      advance = 1'b1; cyc(); advance = 1'b0;
      chk("R10 adv cut", AW'(fetch_valid), 0);
      chk("R10 adv ptr", desc_addr, 32'h3000_0020);
      fetch_start = 1'b1; cyc(); fetch_start = 1'b0;
      chk("R10 new walk", fetch_addr, 32'h3000_0020);
      restart = 1'b1; cyc(); restart = 1'b0;
      chk("R10 rst cut", AW'(fetch_valid), 0);

      // R11: modular wrap near the top of the address space
      base_addr = 32'hFFFF_FFE0; wide_desc = 1'b1; skip_words = '0; do_restart();
      advance = 1'b1; cyc(); advance = 1'b0;
      chk("R11 wrap", desc_addr, 32'h0000_0000);
      skip_words = 5'd31; advance = 1'b1; cyc(); advance = 1'b0;
      chk("R4 max skip", desc_addr, 32'h0000_009C);

      // R1: reset mid-walk
      fetch_start = 1'b1; cyc(); fetch_start = 1'b0;
      base_addr = 32'h4000_0000; rst_n = 1'b0; cyc(); rst_n = 1'b1;
      chk("R1 reset desc", desc_addr, 32'h4000_0000);
      chk("R1 reset valid", AW'(fetch_valid), 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule